// File: doc/BRIEF.md
# Task Stall Manager with Dispatch Lock

This block schedules a fixed set of task engines that all run in parallel. There is no software scheduler. Each engine gets one stall line and runs only while that line is low. For every task the block keeps a state, a priority and a countdown timer. It also keeps one global dispatch lock. Task engines update this storage through a single write port. A write can change a task's state, load its priority, load its timer, or take or release the lock. Each write names a target task, or the calling task for a lock request.

A task that becomes Ready is promoted to Running on its own in the next cycle. A Running task is held off while a task with strictly higher priority is Running or Ready. A periodic tick counts down every non-zero timer, and a Blocked task whose timer runs out is released to Ready. While the dispatch lock is held, every task except its owner is forced into stall. The owner keeps its normal stall value. This lets one task get mutual exclusion without stopping the rest of the hardware.

Top module: `task_stall_mgr`

## Requirements
- R1: Synchronous reset leaves every task Blocked, with priority 0 and timer 0, and the lock free, so every stall line is 1. The state codes on `state_o` are Running=0, Ready=1, Blocked=2 and Suspended=3. Task i occupies bits [2i+1:2i].
- R2: A task in Ready that receives no state write in that cycle is Running after the next clock edge.
- R3: When the lock is free, a task's stall line is 0 exactly when the task is Running and no other task that is Running or Ready has a strictly higher priority number. Tasks with equal priority do not stall each other.
- R4: While the lock is held, the stall line of every task other than the owner is 1.
- R5: While the lock is held, the owner's stall line equals the value R3 gives it.
- R6: On a cycle with `tick` high, every non-zero timer decrements by one, and timers at zero stay at zero. A Blocked task whose timer steps from 1 to 0 shows Ready after that edge.
- R7: A state write shows on `state_o` right after the edge that samples it. It overrides the Ready-to-Running promotion and a timer wake-up that fall in the same cycle.
- R8: A take request from a task while another task owns the lock has no effect. A release from a task that does not own the lock has no effect. The owner may take the lock again or release it.
- R9: A timer load that lands in the same cycle as `tick` stores the loaded value with no decrement.
- R10: The write port decodes `wr_kind` as follows. 0 writes the state from `wr_data[1:0]`. 1 writes the priority from `wr_data[PRIO_W-1:0]`. 2 loads the timer from `wr_data`. 3 is a lock request from task `wr_id`, where `wr_data[0]`=1 takes the lock and 0 releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick pulse, one cycle wide |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | Write kind (R10) |
| wr_id | input | ID_W | Target task, or the calling task for lock requests |
| wr_data | input | TMR_W | Write payload |
| stall_o | output | N_TASKS | Stall line per task, 1 = halt |
| state_o | output | 2*N_TASKS | Packed task states, 2 bits per task |

## Verification
Every write and every tick is sampled at one rising edge. The state, timer and lock registers it touches are updated at that edge. The stall lines are combinational from those registers, so the effect of a stimulus is due in the cycle right after it. A Ready-to-Running promotion needs one more edge. The bench drives one stimulus per cycle on the falling edge and samples both outputs at the next falling edge. At that point it also advances its own arithmetic model of states, timers, priorities and the lock by the same one step, and compares every task's state and stall line.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    typedef enum logic [1:0] {
        TS_RUN = 2'd0,
        TS_RDY = 2'd1,
        TS_BLK = 2'd2,
        TS_SUS = 2'd3
    } tsm_state_e;

    typedef enum logic [1:0] {
        WK_STATE = 2'd0,
        WK_PRIO  = 2'd1,
        WK_TIMER = 2'd2,
        WK_LOCK  = 2'd3
    } tsm_wkind_e;

    // A task competes for the engine while Running or Ready
    function automatic logic is_contender(input logic [1:0] s);
        return (s == TS_RUN) || (s == TS_RDY);
    endfunction

endpackage

// File: rtl/tsm_task_slot.sv
module tsm_task_slot
    import tsm_pkg::*;
#(
    parameter int PRIO_W = 3,
    parameter int TMR_W  = 8,
    parameter int ID_W   = 3,
    parameter int MY_ID  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [TMR_W-1:0]  wr_data,
    output logic [1:0]        state_o,
    output logic [PRIO_W-1:0] prio_o
);

    tsm_state_e        state_q, state_d;
    logic [PRIO_W-1:0] prio_q;
    logic [TMR_W-1:0]  timer_q, timer_d;
    logic              hit, st_wr, tm_wr, pr_wr;

    assign hit   = wr_en && (wr_id == ID_W'(MY_ID));
    assign st_wr = hit && (wr_kind == WK_STATE);
    assign tm_wr = hit && (wr_kind == WK_TIMER);
    assign pr_wr = hit && (wr_kind == WK_PRIO);

    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        if (state_q == TS_RDY) begin
            state_d = TS_RUN;
        end
        if (tick && (timer_q != '0)) begin
            timer_d = timer_q - TMR_W'(1);
            if ((timer_q == TMR_W'(1)) && (state_q == TS_BLK)) begin
                state_d = TS_RDY;
            end
        end
        if (st_wr) begin
            state_d = tsm_state_e'(wr_data[1:0]);
        end
        if (tm_wr) begin
            timer_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_BLK;
            timer_q <= '0;
            prio_q  <= '0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
            if (pr_wr) begin
                prio_q <= wr_data[PRIO_W-1:0];
            end
        end
    end

    assign state_o = state_q;
    assign prio_o  = prio_q;

    p_promote_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == TS_RDY && !st_wr) |=> (state_q == TS_RUN));

    p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
        st_wr |=> (state_q == tsm_state_e'($past(wr_data[1:0]))));

    p_timer_dec_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && timer_q != '0 && !tm_wr) |=> (timer_q == $past(timer_q) - TMR_W'(1)));

    p_expire_wake_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && timer_q == TMR_W'(1) && state_q == TS_BLK && !st_wr) |=> (state_q == TS_RDY));

    p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
        tm_wr |=> (timer_q == $past(wr_data)));

endmodule

// File: rtl/tsm_prio_arbiter.sv
module tsm_prio_arbiter
    import tsm_pkg::*;
#(
    parameter int N_TASKS = 8,
    parameter int PRIO_W  = 3
) (
    input  logic [N_TASKS-1:0][1:0]        st_vec,
    input  logic [N_TASKS-1:0][PRIO_W-1:0] pr_vec,
    output logic [N_TASKS-1:0]             stall_base
);

    for (genvar gi = 0; gi < N_TASKS; gi++) begin : g_task
        logic outranked;
        always_comb begin
            outranked = 1'b0;
            for (int j = 0; j < N_TASKS; j++) begin
                if (is_contender(st_vec[j]) && (pr_vec[j] > pr_vec[gi])) begin
                    outranked = 1'b1;
                end
            end
        end
        assign stall_base[gi] = (st_vec[gi] != TS_RUN) || outranked;
    end

endmodule

// File: rtl/tsm_dispatch_lock.sv
module tsm_dispatch_lock #(
    parameter int N_TASKS = 8,
    parameter int ID_W    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_take,
    input  logic [ID_W-1:0]    req_id,
    input  logic [N_TASKS-1:0] stall_base,
    output logic [N_TASKS-1:0] stall_o
);

    logic               lock_on_q;
    logic [ID_W-1:0]    owner_q;
    logic [N_TASKS-1:0] owner_hot;
    logic               may_take, may_free;

    assign may_take = req_valid && req_take && (!lock_on_q || owner_q == req_id);
    assign may_free = req_valid && !req_take && lock_on_q && (owner_q == req_id);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_on_q <= 1'b0;
            owner_q   <= '0;
        end else if (may_take) begin
            lock_on_q <= 1'b1;
            owner_q   <= req_id;
        end else if (may_free) begin
            lock_on_q <= 1'b0;
        end
    end

    // one-hot decode of the owner, used to leave its line alone
    for (genvar gd = 0; gd < N_TASKS; gd++) begin : g_dec
        assign owner_hot[gd] = lock_on_q && (owner_q == ID_W'(gd));
        assign stall_o[gd]   = (lock_on_q && !owner_hot[gd]) ? 1'b1 : stall_base[gd];

        p_forced_r4: assert property (@(posedge clk) disable iff (rst)
            (lock_on_q && owner_q != ID_W'(gd)) |-> stall_o[gd]);
    end

    p_owner_hot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(owner_hot));

    p_owner_free_r5: assert property (@(posedge clk) disable iff (rst)
        lock_on_q |-> (stall_o[owner_q] == stall_base[owner_q]));

    p_foreign_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (lock_on_q && req_valid && req_id != owner_q) |=> (lock_on_q && owner_q == $past(owner_q)));

endmodule

// File: rtl/task_stall_mgr.sv
module task_stall_mgr
    import tsm_pkg::*;
#(
    parameter int N_TASKS = 8,
    parameter int PRIO_W  = 3,
    parameter int TMR_W   = 8,
    localparam int ID_W   = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 wr_en,
    input  logic [1:0]           wr_kind,
    input  logic [ID_W-1:0]      wr_id,
    input  logic [TMR_W-1:0]     wr_data,
    output logic [N_TASKS-1:0]   stall_o,
    output logic [2*N_TASKS-1:0] state_o
);

    logic [N_TASKS-1:0][1:0]        st_vec;
    logic [N_TASKS-1:0][PRIO_W-1:0] pr_vec;
    logic [N_TASKS-1:0]             stall_base;

    for (genvar gt = 0; gt < N_TASKS; gt++) begin : g_slot
        tsm_task_slot #(
            .PRIO_W (PRIO_W),
            .TMR_W  (TMR_W),
            .ID_W   (ID_W),
            .MY_ID  (gt)
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .wr_en   (wr_en),
            .wr_kind (wr_kind),
            .wr_id   (wr_id),
            .wr_data (wr_data),
            .state_o (st_vec[gt]),
            .prio_o  (pr_vec[gt])
        );
        assign state_o[2*gt +: 2] = st_vec[gt];

        p_unstalled_runs_r3: assert property (@(posedge clk) disable iff (rst)
            !stall_o[gt] |-> (st_vec[gt] == TS_RUN));
    end

    tsm_prio_arbiter #(
        .N_TASKS (N_TASKS),
        .PRIO_W  (PRIO_W)
    ) u_arb (
        .st_vec     (st_vec),
        .pr_vec     (pr_vec),
        .stall_base (stall_base)
    );

    tsm_dispatch_lock #(
        .N_TASKS (N_TASKS),
        .ID_W    (ID_W)
    ) u_lock (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (wr_en && (wr_kind == WK_LOCK)),
        .req_take   (wr_data[0]),
        .req_id     (wr_id),
        .stall_base (stall_base),
        .stall_o    (stall_o)
    );

endmodule

// File: tb/task_stall_mgr_bench.sv
module task_stall_mgr_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_kind = 2'd0;
    logic [2:0]    wr_id = 3'd0;
    logic [7:0]    wr_data = 8'd0;
    logic [NT-1:0] stall_o;
    logic [2*NT-1:0] state_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    int m_st [NT];
    int m_pr [NT];
    int m_tm [NT];
    bit m_lock = 0;
    int m_own = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    task_stall_mgr u_task_stall_mgr (
        .clk (clk), .rst (rst), .tick (tick), .wr_en (wr_en),
        .wr_kind (wr_kind), .wr_id (wr_id), .wr_data (wr_data),
        .stall_o (stall_o), .state_o (state_o)
    );

    function automatic bit exp_stall(input int i);
        bit s;
        s = (m_st[i] != 0);
        for (int j = 0; j < NT; j++)
            if (m_st[j] <= 1 && m_pr[j] > m_pr[i]) s = 1;
        if (m_lock && m_own != i) s = 1;
        return s;
    endfunction

    // one clock cycle of stimulus, then advance the model by one step
    task automatic step(input bit tk, input bit we, input int k, input int id, input int d);
        int nst [NT];
        int ntm [NT];
        tick = tk; wr_en = we; wr_kind = 2'(k); wr_id = 3'(id); wr_data = 8'(d);
        @(negedge clk);
        tick = 0; wr_en = 0;
        for (int i = 0; i < NT; i++) begin
            nst[i] = m_st[i];
            ntm[i] = m_tm[i];
            if (m_st[i] == 1) nst[i] = 0;
            if (tk && m_tm[i] != 0) begin
                ntm[i] = m_tm[i] - 1;
                if (m_tm[i] == 1 && m_st[i] == 2) nst[i] = 1;
            end
            if (we && id == i && k == 0) nst[i] = d % 4;
            if (we && id == i && k == 2) ntm[i] = d;
            if (we && id == i && k == 1) m_pr[i] = d % 8;
        end
        if (we && k == 3) begin
            if (d % 2 == 1 && (!m_lock || m_own == id)) begin
                m_lock = 1; m_own = id;
            end else if (d % 2 == 0 && m_lock && m_own == id) begin
                m_lock = 0;
            end
        end
        for (int i = 0; i < NT; i++) begin
            m_st[i] = nst[i];
            m_tm[i] = ntm[i];
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NT; i++) begin
            n_chk++;
            if (int'(state_o[2*i +: 2]) != m_st[i]) begin
                n_bad++;
                $display("FAIL %s task %0d state: actual %0d expected %0d", req, i, state_o[2*i +: 2], m_st[i]);
            end
            n_chk++;
            if (stall_o[i] != exp_stall(i)) begin
                n_bad++;
                $display("FAIL %s task %0d stall: actual %0b expected %0b", req, i, stall_o[i], exp_stall(i));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NT; i++) begin
            m_st[i] = 2; m_pr[i] = 0; m_tm[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R1");

        // R7 / R2: each task made Ready, then promoted
        for (int i = 0; i < NT; i++) begin
            step(0, 1, 0, i, 1);
            check_all("R7");
            step(0, 0, 0, 0, 0);
            check_all("R2");
        end
        // R3: all equal priority -> nobody stalled
        check_all("R3");

        // R10 / R3: priority sweep, priority = id
        for (int i = 0; i < NT; i++) begin
            step(0, 1, 1, i, i);
            check_all("R3");
        end
        step(0, 1, 0, 7, 3);          // suspend top task
        check_all("R3");

        // R4 / R5 / R8: lock behaviour
        step(0, 1, 3, 5, 1);          // task 5 takes
        check_all("R4");
        step(0, 1, 3, 6, 1);          // foreign take ignored
        check_all("R8");
        step(0, 1, 3, 6, 0);          // foreign release ignored
        check_all("R8");
        step(0, 1, 3, 5, 0);          // owner releases
        check_all("R8");
        step(0, 1, 3, 6, 1);          // task 6 owns, runs
        check_all("R5");
        step(0, 1, 3, 3, 1);          // ignored
        check_all("R8");
        step(0, 1, 3, 6, 1);          // owner re-take
        check_all("R8");
        step(0, 1, 3, 6, 0);
        check_all("R4");

        // R6: timer sweep on task 0, lengths 1..4
        for (int len = 1; len <= 4; len++) begin
            step(0, 1, 0, 0, 2);
            step(0, 1, 2, 0, len);
            check_all("R6");
            for (int t = 1; t < len; t++) begin
                step(1, 0, 0, 0, 0);
                check_all("R6");
            end
            step(1, 0, 0, 0, 0);
            check_all("R6");
            step(0, 0, 0, 0, 0);
            check_all("R2");
        end

        // R7: state write collides with timer expiry
        step(0, 1, 0, 4, 2);
        step(0, 1, 2, 4, 1);
        step(1, 1, 0, 4, 3);
        check_all("R7");

        // R9: timer load lands together with tick
        step(0, 1, 0, 1, 2);
        step(1, 1, 2, 1, 2);
        check_all("R9");
        step(1, 0, 0, 0, 0);
        check_all("R9");
        step(1, 0, 0, 0, 0);
        check_all("R9");
        step(0, 0, 0, 0, 0);
        check_all("R9");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule